// File: doc/BRIEF.md
# Slow-Clock Counter with Match Timer

A timekeeping peripheral with a 32-bit free-running counter that lives in a slow clock domain, nominally 32.768 kHz, next to a fast bus clock. The counter advances on ticks from a programmable prescaler. Software on the bus side controls it through a small register file. Writes to the prescaler trim, the counter load and the match value are carried into the slow domain by toggle handshakes. Each such register shows a pending bit until its value has landed, and a write made while that bit is set is dropped.

A slow-domain compare raises an event when the counter becomes equal to the match value. The bus side records the event as a sticky flag that is cleared by writing 1, and drives a registered interrupt when enabled. The counter is read through a snapshot that the slow domain hands over with a handshake, so a read always returns a whole value. A sticky status bit reports that the slow clock has been seen toggling while the oscillator enable is set.

Register addresses (wr_addr / rd_addr): 0 control, 1 status, 2 trim, 3 counter load (reads 0), 4 counter value (read only), 5 match.

Top module: `slow_counter_timer`

## Requirements
- R1: The counter at address 4 is 32 bits wide and increments by exactly one per prescaler tick, wrapping from 0xFFFFFFFF to 0.
- R2: A trim value N at address 2 (15 bits, read back from address 2) makes one counter tick per N+1 slow clock cycles; N=0 ticks on every slow cycle.
- R3: The counter advances only while control bit 0 (oscillator enable) and control bit 1 (counter enable) are both set; with either clear it holds its value.
- R4: Status bit 0 (clock present) is 0 after reset, becomes 1 after slow clock edges are seen with control bit 0 set, and stays 1 when that bit is cleared again.
- R5: A write to trim (address 2) sets status bit 1 until the new value is in use in the slow domain; a trim write made while bit 1 is set is ignored.
- R6: A write to counter load (address 3) sets status bit 2 until the counter holds the written value; a load write made while bit 2 is set is ignored.
- R7: A write to match (address 5) sets status bit 3 until the value is in use; a match write made while bit 3 is set is ignored.
- R8: When the counter becomes equal to the match value (through counting, a load or a match write), status bit 4 is set and stays set until a write to address 1 with bit 4 equal to 1.
- R9: Output irq is status bit 4 gated by control bit 2 (interrupt enable), registered; clearing either drops irq.
- R10: A read of address 4 at any time returns a whole, recent counter value; while counting, successive reads never go backwards between wraps.
- R11: After reset, control, status, trim, match and counter value all read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, also resynchronised into the slow domain |
| slow_clk | input | 1 | Slow counting clock |
| wr_en | input | 1 | Register write strobe, one bus cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, registered one bus cycle after rd_addr |
| irq | output | 1 | Match interrupt, level |

## Verification
A pending bit that never clears or clears early shows at once in the status word and, a few slow cycles later, as a counter or trim readback that holds the wrong or the dropped value. A wrong prescaler divide or a counter that moves while disabled shows as a count that is off after a run of known length, since the bench turns counting on and off around a fixed number of slow cycles. A lost or doubled match event shows at the status flag and irq within a few bus cycles of the slow-domain equality. The clock-present bit is checked both before and after the oscillator enable toggles, so a bit that is not sticky is caught on the following read.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIM  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd5;

  // status bit positions
  localparam int ST_PRES  = 0;
  localparam int ST_TRIM  = 1;
  localparam int ST_LOAD  = 2;
  localparam int ST_MATCH = 3;
  localparam int ST_FLAG  = 4;

  // write channel indices
  localparam int CH_TRIM  = 0;
  localparam int CH_LOAD  = 1;
  localparam int CH_MATCH = 2;
  localparam int NCH      = 3;

  typedef struct packed {
    logic irq_en;
    logic cnt_en;
    logic osc_en;
  } ctrl_t;
endpackage

// File: rtl/sct_sync.sv
module sct_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sct_xfer.sv
// Toggle handshake carrying one held word from a source to a destination clock.
module sct_xfer #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_send,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);
  logic             req_t;
  logic             ack_seen;
  logic             req_seen;
  logic             req_last;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_t  <= 1'b0;
      hold_q <= '0;
    end else if (src_send && !src_busy) begin
      req_t  <= ~req_t;
      hold_q <= src_data;
    end
  end

  sct_sync #(.WIDTH(1), .STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst(src_rst), .d(req_last), .q(ack_seen)
  );

  assign src_busy = req_t ^ ack_seen;

  sct_sync #(.WIDTH(1), .STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst(dst_rst), .d(req_t), .q(req_seen)
  );

  always_ff @(posedge dst_clk) begin
    if (dst_rst) req_last <= 1'b0;
    else         req_last <= req_seen;
  end

  assign dst_valid = req_seen ^ req_last;
  assign dst_data  = hold_q;

  // R5 R6 R7: an accepted write raises pending on the next cycle
  assert_pend_set_R5: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_send && !src_busy) |=> src_busy);

  // R6 R7: a write made while pending leaves the held word untouched
  assert_ignore_busy_R7: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_send && src_busy) |=> $stable(hold_q));

  // R6: each transfer is applied exactly once on the destination side
  assert_single_apply_R6: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_valid |=> !dst_valid);
endmodule

// File: rtl/sct_slow_core.sv
// Slow domain: prescaler, counter, match compare.
module sct_slow_core #(
  parameter int CW = 32,
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          trim_ld,
  input  logic [TW-1:0] trim_val,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_val,
  input  logic          match_ld,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] cnt_o,
  output logic          evt_t_o
);
  logic [TW-1:0] trim_q;
  logic [TW-1:0] div_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] match_q;
  logic          eq_q;
  logic          evt_t;
  logic          tick;
  logic          eq_now;

  assign tick   = run && !trim_ld && (div_q == trim_q);
  assign eq_now = (cnt_q == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q <= '0;
      div_q  <= '0;
    end else if (trim_ld) begin
      trim_q <= trim_val;
      div_q  <= '0;
    end else if (run) begin
      div_q  <= (div_q == trim_q) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_val;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      eq_q    <= 1'b1;
      evt_t   <= 1'b0;
    end else begin
      if (match_ld) match_q <= match_val;
      eq_q <= eq_now;
      if (eq_now && !eq_q) evt_t <= ~evt_t;
    end
  end

  assign cnt_o   = cnt_q;
  assign evt_t_o = evt_t;

  // R2: the divider phase never passes the trim value
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (rst)
    div_q <= trim_q);

  // R1: without a load the counter holds or steps by one, modulo 2^CW
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    !cnt_ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R3: with the run gate low the counter only moves by a load
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_ld) |=> $stable(cnt_q));

  // R8: an event toggle follows only a fresh equality
  assert_event_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_t != $past(evt_t)) |-> eq_q);
endmodule

// File: rtl/slow_counter_timer.sv
module slow_counter_timer #(
  parameter int CW     = 32,
  parameter int TW     = 15,
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      slow_clk,
  input  logic                      wr_en,
  input  logic [sct_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic [sct_pkg::ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]             rd_data,
  output logic                      irq
);
  import sct_pkg::*;

  localparam logic [CW-1:0] TRIM_MASK = {{(CW-TW){1'b0}}, {TW{1'b1}}};

  // ---------------- slow reset ----------------
  logic srst;
  sct_sync #(.WIDTH(1), .STAGES(STAGES)) u_srst (
    .clk(slow_clk), .rst(1'b0), .d(rst), .q(srst)
  );

  // ---------------- bus registers ----------------
  ctrl_t         ctrl_q;
  logic          present_q;
  logic          flag_q;
  logic          irq_q;
  logic [CW-1:0] cnt_view_q;
  logic [CW-1:0] rd_q;
  logic [CW-1:0] rd_next;

  logic          ch_busy  [NCH];
  logic          ch_valid [NCH];
  logic [CW-1:0] ch_data  [NCH];

  // ---------------- write channels ----------------
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_A =
      (g == CH_TRIM) ? A_TRIM : ((g == CH_LOAD) ? A_LOAD : A_MATCH);
    logic [CW-1:0] src_d;
    assign src_d = (g == CH_TRIM) ? (wr_data & TRIM_MASK) : wr_data;

    sct_xfer #(.WIDTH(CW), .STAGES(STAGES)) u_xfer (
      .src_clk  (clk),
      .src_rst  (rst),
      .src_send (wr_en && (wr_addr == CH_A)),
      .src_data (src_d),
      .src_busy (ch_busy[g]),
      .dst_clk  (slow_clk),
      .dst_rst  (srst),
      .dst_valid(ch_valid[g]),
      .dst_data (ch_data[g])
    );
  end

  // ---------------- slow domain ----------------
  logic [1:0]    gate_s;
  logic          run_s;
  logic          hb_t;
  logic          evt_t;
  logic [CW-1:0] cnt_slow;

  sct_sync #(.WIDTH(2), .STAGES(STAGES)) u_gate_sync (
    .clk(slow_clk), .rst(srst), .d({ctrl_q.cnt_en, ctrl_q.osc_en}), .q(gate_s)
  );
  assign run_s = gate_s[0] & gate_s[1];

  always_ff @(posedge slow_clk) begin
    if (srst)           hb_t <= 1'b0;
    else if (gate_s[0]) hb_t <= ~hb_t;
  end

  sct_slow_core #(.CW(CW), .TW(TW)) u_core (
    .clk      (slow_clk),
    .rst      (srst),
    .run      (run_s),
    .trim_ld  (ch_valid[CH_TRIM]),
    .trim_val (ch_data[CH_TRIM][TW-1:0]),
    .cnt_ld   (ch_valid[CH_LOAD]),
    .cnt_val  (ch_data[CH_LOAD]),
    .match_ld (ch_valid[CH_MATCH]),
    .match_val(ch_data[CH_MATCH]),
    .cnt_o    (cnt_slow),
    .evt_t_o  (evt_t)
  );

  // ---------------- counter snapshot back to bus ----------------
  logic          snap_busy;
  logic          snap_valid;
  logic [CW-1:0] snap_data;

  sct_xfer #(.WIDTH(CW), .STAGES(STAGES)) u_snap (
    .src_clk  (slow_clk),
    .src_rst  (srst),
    .src_send (!snap_busy),
    .src_data (cnt_slow),
    .src_busy (snap_busy),
    .dst_clk  (clk),
    .dst_rst  (rst),
    .dst_valid(snap_valid),
    .dst_data (snap_data)
  );

  // ---------------- events into bus domain ----------------
  logic [1:0] ev_s;
  logic [1:0] ev_last;
  logic       hb_edge;
  logic       evt_edge;

  sct_sync #(.WIDTH(2), .STAGES(STAGES)) u_ev_sync (
    .clk(clk), .rst(rst), .d({evt_t, hb_t}), .q(ev_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ev_last <= '0;
    else     ev_last <= ev_s;
  end

  assign hb_edge  = ev_s[0] ^ ev_last[0];
  assign evt_edge = ev_s[1] ^ ev_last[1];

  // ---------------- bus state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      present_q  <= 1'b0;
      flag_q     <= 1'b0;
      irq_q      <= 1'b0;
      cnt_view_q <= '0;
    end else begin
      if (wr_en && (wr_addr == A_CTRL)) ctrl_q <= ctrl_t'(wr_data[2:0]);
      if (hb_edge) present_q <= 1'b1;
      if (evt_edge)
        flag_q <= 1'b1;
      else if (wr_en && (wr_addr == A_STAT) && wr_data[ST_FLAG])
        flag_q <= 1'b0;
      irq_q <= flag_q & ctrl_q.irq_en;
      if (snap_valid) cnt_view_q <= snap_data;
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CTRL:  rd_next[2:0] = ctrl_q;
      A_STAT: begin
        rd_next[ST_PRES]  = present_q;
        rd_next[ST_TRIM]  = ch_busy[CH_TRIM];
        rd_next[ST_LOAD]  = ch_busy[CH_LOAD];
        rd_next[ST_MATCH] = ch_busy[CH_MATCH];
        rd_next[ST_FLAG]  = flag_q;
      end
      A_TRIM:  rd_next = ch_data[CH_TRIM];
      A_COUNT: rd_next = cnt_view_q;
      A_MATCH: rd_next = ch_data[CH_MATCH];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R4: clock-present never drops once seen
  assert_present_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    present_q |=> present_q);

  // R8: a synchronised match event always leaves the flag set
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    evt_edge |=> flag_q);

  // R9: irq only follows a flag that was set one cycle earlier
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag_q));
endmodule

// File: tb/slow_counter_timer_test.sv
`timescale 1ns/1ps
module slow_counter_timer_test;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;

  localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1, R_TRIM = 3'd2,
                         R_LOAD = 3'd3, R_CNT = 3'd4, R_MATCH = 3'd5;

  always #2.5 clk = ~clk;
  always #20  slow_clk = ~slow_clk;

  slow_counter_timer uut (
    .clk(clk), .rst(rst), .slow_clk(slow_clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(R_STAT, s);
      if ((s & 32'h0000_000E) == 0) return;
    end
    chk(1'b0, "idle pending never cleared (R5/R6/R7)", s, 32'h0);
  endtask

  function automatic bit near(input logic [31:0] a, input logic [31:0] e, input int tol);
    int d;
    d = int'(a - e);
    return (d <= tol) && (d >= -tol);
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, prev, lv;
    int n;
    void'($urandom(32'd1234));
    repeat (40) @(negedge clk);
    rst = 1'b0;
    slow_wait(6);

    // R11 reset state
    bus_rd(R_STAT, v);  chk(v == 0, "R11 status after reset", v, 0);
    bus_rd(R_CTRL, v);  chk(v == 0, "R11 control after reset", v, 0);
    bus_rd(R_CNT, v);   chk(v == 0, "R11 count after reset", v, 0);
    bus_rd(R_TRIM, v);  chk(v == 0, "R11 trim after reset", v, 0);
    chk(irq == 1'b0, "R11 irq after reset", {31'b0, irq}, 0);

    // R4 clock present, sticky
    slow_wait(8);
    bus_rd(R_STAT, v); chk(v[0] == 1'b0, "R4 present before osc enable", v, 0);
    bus_wr(R_CTRL, 32'h1);
    slow_wait(8);
    bus_rd(R_STAT, v); chk(v[0] == 1'b1, "R4 present after osc enable", v, 1);
    bus_wr(R_CTRL, 32'h0);
    slow_wait(8);
    bus_rd(R_STAT, v); chk(v[0] == 1'b1, "R4 present sticky", v, 1);

    // R6 load pending, second write ignored
    bus_wr(R_LOAD, 32'h1234_5678);
    bus_rd(R_STAT, v); chk(v[2] == 1'b1, "R6 load pending set", v, 32'h4);
    bus_wr(R_LOAD, 32'h0000_DEAD);
    wait_idle();
    slow_wait(12);
    bus_rd(R_CNT, v); chk(v == 32'h1234_5678, "R6 load value, second ignored", v, 32'h1234_5678);

    // R3 gating: only one of the two enables set
    bus_wr(R_CTRL, 32'h1); slow_wait(30);
    bus_rd(R_CNT, v); chk(v == 32'h1234_5678, "R3 osc only holds", v, 32'h1234_5678);
    bus_wr(R_CTRL, 32'h2); slow_wait(30);
    bus_rd(R_CNT, v); chk(v == 32'h1234_5678, "R3 count-enable only holds", v, 32'h1234_5678);
    bus_wr(R_CTRL, 32'h0);

    // R5 trim pending, second write ignored
    bus_wr(R_TRIM, 32'd5);
    bus_rd(R_STAT, v); chk(v[1] == 1'b1, "R5 trim pending set", v, 32'h2);
    bus_wr(R_TRIM, 32'd9);
    wait_idle();
    bus_rd(R_TRIM, v); chk(v == 32'd5, "R5 trim kept, second ignored", v, 5);

    // R2 random divides
    for (int t = 0; t < 4; t++) begin
      n = (t == 0) ? 0 : int'($urandom % 6);
      bus_wr(R_TRIM, n);
      wait_idle();
      bus_wr(R_LOAD, 32'h0);
      wait_idle();
      bus_wr(R_CTRL, 32'h3);
      slow_wait((n + 1) * 20);
      bus_wr(R_CTRL, 32'h0);
      slow_wait(12);
      bus_rd(R_CNT, v);
      chk(near(v, 32'd20, 2), $sformatf("R2 divide by %0d", n + 1), v, 32'd20);
    end

    // R1 wrap
    bus_wr(R_TRIM, 32'd0); wait_idle();
    bus_wr(R_LOAD, 32'hFFFF_FFFC); wait_idle();
    bus_wr(R_CTRL, 32'h3);
    slow_wait(10);
    bus_wr(R_CTRL, 32'h0);
    slow_wait(12);
    bus_rd(R_CNT, v); chk(near(v, 32'd6, 2), "R1 wrap through zero", v, 32'd6);

    // R10 monotonic reads while running
    bus_wr(R_LOAD, 32'd1000); wait_idle();
    bus_wr(R_CTRL, 32'h3);
    slow_wait(4);
    bus_rd(R_CNT, prev);
    for (int k = 0; k < 5; k++) begin
      slow_wait(3 + int'($urandom % 5));
      bus_rd(R_CNT, v);
      chk((v >= prev) && (v < 32'd1200), "R10 reads never go back", v, prev);
      prev = v;
    end
    bus_wr(R_CTRL, 32'h0);

    // R10 random loads read back with counting stopped
    for (int k = 0; k < 3; k++) begin
      lv = $urandom;
      bus_wr(R_LOAD, lv); wait_idle(); slow_wait(12);
      bus_rd(R_CNT, v); chk(v == lv, "R10 count readback", v, lv);
    end

    // R8 / R9 match through counting
    bus_wr(R_LOAD, 32'd100); wait_idle();
    bus_wr(R_MATCH, 32'd120); wait_idle();
    slow_wait(8);
    bus_wr(R_STAT, 32'h10);
    bus_rd(R_STAT, v); chk(v[4] == 1'b0, "R8 flag clear before match", v, 0);
    bus_wr(R_CTRL, 32'h7);
    slow_wait(40);
    bus_rd(R_STAT, v); chk(v[4] == 1'b1, "R8 flag on match", v, 32'h10);
    chk(irq == 1'b1, "R9 irq with enable", {31'b0, irq}, 1);
    bus_wr(R_CTRL, 32'h3);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b0, "R9 irq off without enable", {31'b0, irq}, 0);
    bus_rd(R_STAT, v); chk(v[4] == 1'b1, "R8 flag stays set", v, 32'h10);
    bus_wr(R_CTRL, 32'h4);
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b1, "R9 irq back on enable", {31'b0, irq}, 1);
    bus_wr(R_STAT, 32'h10);
    bus_rd(R_STAT, v); chk(v[4] == 1'b0, "R8 write-one clears flag", v, 0);
    chk(irq == 1'b0, "R9 irq drops with flag", {31'b0, irq}, 0);
    bus_wr(R_CTRL, 32'h0);

    // R7 match pending, second write ignored
    bus_wr(R_LOAD, 32'd3); wait_idle(); slow_wait(8);
    bus_wr(R_STAT, 32'h10);
    bus_wr(R_MATCH, 32'd50);
    bus_rd(R_STAT, v); chk(v[3] == 1'b1, "R7 match pending set", v, 32'h8);
    bus_wr(R_MATCH, 32'd3);
    wait_idle(); slow_wait(12);
    bus_rd(R_MATCH, v); chk(v == 32'd50, "R7 match kept, second ignored", v, 50);
    bus_rd(R_STAT, v); chk(v[4] == 1'b0, "R7 ignored write raised no match", v, 0);
    bus_wr(R_MATCH, 32'd3); wait_idle(); slow_wait(8);
    bus_rd(R_STAT, v); chk(v[4] == 1'b1, "R8 match write onto stopped count", v, 32'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule